// File: doc/BRIEF.md
# Slow-Clock Reset Controller with Exponential Pin Stretcher

This block runs on the always-on slow clock and decides when the processor and the peripherals are held in reset. It drives the shared board reset line as an open-drain output: it either pulls the line low or releases it. When it pulls the line low, the low time is a power of two of slow-clock cycles, set by a 4-bit exponent in a key-protected mode register. This gives other devices on the same line a reset of known length.

A reset starts from one of four causes: power-up, a watchdog fault, a keyed software request, or a user pulling the line low from outside. The line input passes through a synchroniser. The controller masks the line while it drives it, and for the synchroniser latency after it releases it. A low level it produced itself is therefore never read as a user reset. The cause of the most recent reset can be read back from a status word.

The register port is a single-cycle write strobe with a 1-bit address. Address 0 is the control register on a write and the status register on a read. Address 1 is the mode register for both reads and writes. Read data is combinational.

Top module: `rstgen_top`

## Requirements
- R1: When the controller drives the line, `rst_pin_oe` stays high for exactly 2^(E+1) slow-clock cycles, where E is the stretch exponent. For E=13 this is 16384 cycles, and for E=15 it is 65536 cycles.
- R2: A write to address 1 with key 0xA5 in bits 31:24 loads E from bits 11:8. A read of address 1 returns E in bits 11:8 and zero in every other bit. After power-up, E is 0.
- R3: A write to address 1 whose key is not 0xA5 changes nothing. The read-back value of E stays the same, and so does the length of the next pulse.
- R4: A write to address 0 with key 0xA5 and bit 0 set is a software reset. It asserts `proc_rst_n` low, `periph_rst_n` low and `rst_pin_oe` high, all for the same 2^(E+1) cycles, and records cause 3. The same write with a wrong key has no effect.
- R5: A one-cycle `wdt_fault` from idle holds `proc_rst_n` low for exactly 3 cycles and records cause 2.
- R6: When `wdt_proc_only` is 0 during a watchdog fault, `periph_rst_n` is also low for those 3 cycles, and the line is driven for 2^(E+1) cycles.
- R7: When `wdt_proc_only` is 1 during a watchdog fault, only `proc_rst_n` is asserted. `periph_rst_n` stays high and the line is not driven.
- R8: The low level that the controller drives on the line never causes a user reset. This includes the cycles after release, while the synchronised line is still low. After every driven pulse the recorded cause is unchanged and both resets are released.
- R9: When the line is pulled low from outside while the controller is idle, both resets assert on the third clock edge after the line falls. They stay asserted while the line is low and release on the third edge after it rises. The recorded cause is 4, and the controller does not drive the line.
- R10: A software request or a watchdog fault that arrives while a reset sequence or a line pulse is running is ignored. The running pulse keeps its length, and the recorded cause is unchanged.
- R11: While `por_n` is low, and for 3 cycles after it rises, both resets are asserted and the line is not driven. After that the recorded cause is 0.
- R12: A read of address 0 returns the last cause in bits 2:0 and zero in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow always-on clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control/status, 1 = mode |
| bus_wdata | input | 32 | Write data, key in bits 31:24 |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| wdt_fault | input | 1 | Watchdog fault pulse |
| wdt_proc_only | input | 1 | 1 = a watchdog fault resets only the processor |
| rst_pin_in | input | 1 | Level of the board reset line |
| rst_pin_oe | output | 1 | 1 = pull the board reset line low |
| proc_rst_n | output | 1 | Processor reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |

## Verification
The bench sweeps E over several values and measures the exact pulse length. A counter with an off-by-one error, or one that overflows at E=15, would miss by a cycle or collapse to a short pulse. After every self-driven pulse it checks the recorded cause. A mask that ignores the synchroniser tail would record a false user reset (cause 4) and hold both resets. It sends a second software request and a watchdog fault in the middle of a pulse; a design that accepts them would lengthen the pulse or overwrite the cause. It also tries wrong keys and the processor-only watchdog mode; a design that decodes these loosely would move E or assert the peripheral reset.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

  localparam logic [7:0] WR_KEY = 8'hA5;

  typedef enum logic [2:0] {
    CAUSE_POWER = 3'd0,
    CAUSE_WDOG  = 3'd2,
    CAUSE_SOFT  = 3'd3,
    CAUSE_USER  = 3'd4
  } cause_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_WDOG,
    ST_SOFT,
    ST_USER
  } state_e;

  // Number of cycles the line is held for exponent e: 2^(e+1).
  function automatic logic [31:0] stretch_cycles(input logic [7:0] e);
    return 32'd1 << ({24'd0, e} + 32'd1);
  endfunction

endpackage

// File: rtl/rstgen_pin_sync.sv
module rstgen_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic pin_level
);

  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= pin_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign pin_level = chain[STAGES-1];

endmodule

// File: rtl/rstgen_stretch.sv
module rstgen_stretch #(
  parameter int ERSTL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ERSTL_W-1:0] erstl,
  output logic               active,
  output logic               last
);

  localparam int CNT_W = (1 << ERSTL_W) + 1;

  logic [CNT_W-1:0] cnt;

  // Count reload for exponent e: 2^(e+1) - 1 (the counter runs down to zero).
  function automatic logic [CNT_W-1:0] reload(input logic [ERSTL_W-1:0] e);
    logic [ERSTL_W:0] sh;
    sh = {1'b0, e} + {{ERSTL_W{1'b0}}, 1'b1};
    return ({{(CNT_W-1){1'b0}}, 1'b1} << sh) - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  assign last = active && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= reload(erstl);
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  // A running pulse is only cut short by its final count.
  p_pulse_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last && !start) |=> active);

  // A new pulse never starts on top of a running one.
  p_start_when_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);

endmodule

// File: rtl/rstgen_regs.sv
module rstgen_regs #(
  parameter int ERSTL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic [2:0]         cause,
  output logic [31:0]        bus_rdata,
  output logic [ERSTL_W-1:0] erstl,
  output logic               sw_req
);
  import rstgen_pkg::*;

  localparam int FIELD_LSB = 8;

  logic key_ok;
  logic mode_wr_ok;

  assign key_ok     = (bus_wdata[31:24] == WR_KEY);
  assign mode_wr_ok = bus_wr && bus_addr && key_ok;
  assign sw_req     = bus_wr && !bus_addr && key_ok && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          erstl <= '0;
    else if (mode_wr_ok) erstl <= bus_wdata[FIELD_LSB +: ERSTL_W];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr) bus_rdata[FIELD_LSB +: ERSTL_W] = erstl;
    else          bus_rdata[2:0] = cause;
  end

  p_badkey_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && (bus_wdata[31:24] != WR_KEY)) |=> $stable(erstl));

endmodule

// File: rtl/rstgen_fsm.sv
module rstgen_fsm #(
  parameter int HOLD_CYCLES = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wdt_fault,
  input  logic       wdt_proc_only,
  input  logic       sw_req,
  input  logic       pin_level,
  input  logic       drive_active,
  input  logic       drive_last,
  output logic       stretch_start,
  output logic       enter_user,
  output logic       proc_rst_n,
  output logic       periph_rst_n,
  output logic [2:0] cause
);
  import rstgen_pkg::*;

  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam int GW = $clog2(SYNC_STAGES + 1);

  state_e        state;
  cause_e        cause_q;
  logic [HW-1:0] hold;
  logic [GW-1:0] guard;
  logic          wd_only;

  logic idle_free;
  logic take_wdog;
  logic take_soft;

  assign idle_free  = (state == ST_IDLE) && !drive_active && (guard == '0);
  assign take_wdog  = idle_free && wdt_fault;
  assign take_soft  = idle_free && !wdt_fault && sw_req;
  assign enter_user = idle_free && !wdt_fault && !sw_req && !pin_level;

  assign stretch_start = take_soft || (take_wdog && !wdt_proc_only);

  // Hold off line sampling while the synchroniser still carries our own low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            guard <= '0;
    else if (drive_active) guard <= GW'(SYNC_STAGES);
    else if (guard != '0)  guard <= guard - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_BOOT;
      hold    <= HW'(HOLD_CYCLES);
      wd_only <= 1'b0;
      cause_q <= CAUSE_POWER;
    end else begin
      case (state)
        ST_BOOT, ST_WDOG: begin
          if (hold == '0) state <= ST_IDLE;
          else            hold  <= hold - 1'b1;
        end
        ST_IDLE: begin
          if (take_wdog) begin
            state   <= ST_WDOG;
            hold    <= HW'(HOLD_CYCLES - 1);
            wd_only <= wdt_proc_only;
            cause_q <= CAUSE_WDOG;
          end else if (take_soft) begin
            state   <= ST_SOFT;
            cause_q <= CAUSE_SOFT;
          end else if (enter_user) begin
            state   <= ST_USER;
            cause_q <= CAUSE_USER;
          end
        end
        ST_SOFT: if (drive_last) state <= ST_IDLE;
        ST_USER: if (pin_level)  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign proc_rst_n   = (state == ST_IDLE);
  assign periph_rst_n = !((state == ST_BOOT) || (state == ST_SOFT) ||
                          (state == ST_USER) || ((state == ST_WDOG) && !wd_only));
  assign cause = cause_q;

  // Independent age counter for the watchdog window.
  logic [HW-1:0] wd_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wd_age <= '0;
    else if (state == ST_WDOG)  wd_age <= wd_age + 1'b1;
    else                        wd_age <= '0;
  end

  p_wdog_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WDOG) |-> (wd_age < HW'(HOLD_CYCLES)));

  p_wdog_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WDOG) && (wd_age == HW'(HOLD_CYCLES - 1))) |=> (state == ST_IDLE));

  p_no_self_user_r8: assert property (@(posedge clk) disable iff (!rst_n)
    enter_user |-> (!drive_active && !$past(drive_active)));

  p_proc_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WDOG) && wd_only) |-> (periph_rst_n && !drive_active));

  p_user_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_USER) && !pin_level) |=> (state == ST_USER));

endmodule

// File: rtl/rstgen_top.sv
module rstgen_top #(
  parameter int ERSTL_W     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 3
) (
  input  logic        clk_slow,
  input  logic        por_n,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        wdt_fault,
  input  logic        wdt_proc_only,
  input  logic        rst_pin_in,
  output logic        rst_pin_oe,
  output logic        proc_rst_n,
  output logic        periph_rst_n
);

  logic [ERSTL_W-1:0] erstl;
  logic               sw_req;
  logic [2:0]         cause;
  logic               pin_level;
  logic               drive_active;
  logic               drive_last;
  logic               stretch_start;
  logic               enter_user;

  rstgen_regs #(.ERSTL_W(ERSTL_W)) u_regs (
    .clk(clk_slow), .rst_n(por_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cause(cause), .bus_rdata(bus_rdata),
    .erstl(erstl), .sw_req(sw_req)
  );

  rstgen_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_slow), .rst_n(por_n), .pin_in(rst_pin_in), .pin_level(pin_level)
  );

  rstgen_stretch #(.ERSTL_W(ERSTL_W)) u_stretch (
    .clk(clk_slow), .rst_n(por_n), .start(stretch_start), .erstl(erstl),
    .active(drive_active), .last(drive_last)
  );

  rstgen_fsm #(.HOLD_CYCLES(HOLD_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
    .clk(clk_slow), .rst_n(por_n), .wdt_fault(wdt_fault),
    .wdt_proc_only(wdt_proc_only), .sw_req(sw_req), .pin_level(pin_level),
    .drive_active(drive_active), .drive_last(drive_last),
    .stretch_start(stretch_start), .enter_user(enter_user),
    .proc_rst_n(proc_rst_n), .periph_rst_n(periph_rst_n), .cause(cause)
  );

  assign rst_pin_oe = drive_active;

endmodule

// File: tb/rstgen_top_bench.sv
`timescale 1ns/1ps
module rstgen_top_bench;
  import rstgen_pkg::*;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_fault = 1'b0;
  logic        wdt_proc_only = 1'b0;
  logic        btn_n = 1'b1;
  logic        rst_pin_in;
  logic        rst_pin_oe;
  logic        proc_rst_n;
  logic        periph_rst_n;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // Open-drain line: low whenever the block pulls it or the button is pressed.
  assign rst_pin_in = rst_pin_oe ? 1'b0 : btn_n;

  rstgen_top u_rstgen_top (
    .clk_slow(clk), .por_n(por_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_fault(wdt_fault),
    .wdt_proc_only(wdt_proc_only), .rst_pin_in(rst_pin_in),
    .rst_pin_oe(rst_pin_oe), .proc_rst_n(proc_rst_n), .periph_rst_n(periph_rst_n)
  );

  task automatic check_eq(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic fire_wdog(input logic proc_only);
    @(negedge clk);
    wdt_fault = 1'b1; wdt_proc_only = proc_only;
    @(negedge clk);
    wdt_fault = 1'b0;
  endtask

  // Counts, from the current negedge on, the cycles each output is active.
  task automatic measure(output int n_oe, output int n_proc, output int n_peri);
    int it;
    it = 0; n_oe = 0; n_proc = 0; n_peri = 0;
    while ((rst_pin_oe || !proc_rst_n || !periph_rst_n) && it < 70000) begin
      if (rst_pin_oe)    n_oe++;
      if (!proc_rst_n)   n_proc++;
      if (!periph_rst_n) n_peri++;
      it++;
      @(negedge clk);
    end
  endtask

  task automatic settle_and_cause(input string req, input int exp_cause);
    logic [31:0] d;
    repeat (6) @(negedge clk);
    check_eq({req, " resets released"}, {proc_rst_n, periph_rst_n}, 2'b11);
    bus_read(1'b0, d);
    check_eq({req, " cause"}, d, exp_cause);
  endtask

  function automatic logic [31:0] mode_word(input logic [7:0] key, input int e);
    return {key, 12'd0, 4'(e), 8'd0};
  endfunction

  initial begin
    logic [31:0] d;
    int n_oe, n_proc, n_peri;

    // R11: held in reset during power-on.
    repeat (4) @(negedge clk);
    check_eq("R11 proc during por", proc_rst_n, 0);
    check_eq("R11 periph during por", periph_rst_n, 0);
    check_eq("R11 pin during por", rst_pin_oe, 0);
    por_n = 1'b1;
    @(negedge clk);
    measure(n_oe, n_proc, n_peri);
    check_eq("R11 proc hold after por", n_proc, 3);
    check_eq("R11 periph hold after por", n_peri, 3);
    check_eq("R11 no pin drive", n_oe, 0);
    bus_read(1'b0, d);
    check_eq("R11 R12 power-up cause", d, 0);
    bus_read(1'b1, d);
    check_eq("R2 exponent reset value", d, 0);

    // R1 R2 R4 R8: software pulses over a sweep of exponents.
    for (int e = 0; e <= 6; e++) begin
      bus_write(1'b1, mode_word(8'hA5, e));
      bus_read(1'b1, d);
      check_eq("R2 mode readback", d, e << 8);
      bus_write(1'b0, {8'hA5, 24'd1});
      measure(n_oe, n_proc, n_peri);
      check_eq("R1 pulse length", n_oe, stretch_cycles(8'(e)));
      check_eq("R4 proc length", n_proc, stretch_cycles(8'(e)));
      check_eq("R4 periph length", n_peri, stretch_cycles(8'(e)));
      settle_and_cause("R8 R4", 3);
    end

    // R3: wrong key leaves the exponent alone.
    bus_write(1'b1, mode_word(8'h5A, 9));
    bus_read(1'b1, d);
    check_eq("R3 mode unchanged", d, 6 << 8);
    bus_write(1'b0, {8'hA5, 24'd1});
    measure(n_oe, n_proc, n_peri);
    check_eq("R3 pulse uses old exponent", n_oe, 128);
    settle_and_cause("R3", 3);

    // R4: control write with a wrong key does nothing.
    bus_write(1'b0, {8'h00, 24'd1});
    check_eq("R4 badkey no pin", rst_pin_oe, 0);
    check_eq("R4 badkey no proc reset", proc_rst_n, 1);

    // R5 R6: watchdog with full reset.
    for (int e = 0; e <= 3; e++) begin
      bus_write(1'b1, mode_word(8'hA5, e));
      fire_wdog(1'b0);
      measure(n_oe, n_proc, n_peri);
      check_eq("R5 proc window", n_proc, 3);
      check_eq("R6 periph window", n_peri, 3);
      check_eq("R6 pin length", n_oe, stretch_cycles(8'(e)));
      settle_and_cause("R5 R8", 2);
    end

    // R7: processor-only watchdog.
    bus_write(1'b1, mode_word(8'hA5, 4));
    fire_wdog(1'b1);
    measure(n_oe, n_proc, n_peri);
    check_eq("R7 proc window", n_proc, 3);
    check_eq("R7 periph untouched", n_peri, 0);
    check_eq("R7 pin untouched", n_oe, 0);
    settle_and_cause("R7", 2);
    wdt_proc_only = 1'b0;

    // R10: requests during a running pulse are ignored.
    bus_write(1'b1, mode_word(8'hA5, 3));
    bus_write(1'b0, {8'hA5, 24'd1});
    n_oe = 0;
    for (int it = 0; it < 200 && rst_pin_oe; it++) begin
      n_oe++;
      bus_wr = (n_oe == 4); bus_addr = 1'b0;
      bus_wdata = (n_oe == 4) ? {8'hA5, 24'd1} : '0;
      wdt_fault = (n_oe == 7);
      @(negedge clk);
    end
    bus_wr = 1'b0; wdt_fault = 1'b0; bus_wdata = '0;
    check_eq("R10 pulse not extended", n_oe, 16);
    settle_and_cause("R10", 3);

    // R9: external low on the line.
    btn_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_eq("R9 not yet asserted", proc_rst_n, 1);
    @(negedge clk);
    check_eq("R9 proc asserted", proc_rst_n, 0);
    check_eq("R9 periph asserted", periph_rst_n, 0);
    repeat (20) @(negedge clk);
    check_eq("R9 proc held", proc_rst_n, 0);
    check_eq("R9 no self drive", rst_pin_oe, 0);
    bus_read(1'b0, d);
    check_eq("R9 R12 user cause", d, 4);
    btn_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_eq("R9 still held", proc_rst_n, 0);
    @(negedge clk);
    check_eq("R9 released", {proc_rst_n, periph_rst_n}, 2'b11);

    // R1: long settings.
    bus_write(1'b1, mode_word(8'hA5, 13));
    bus_write(1'b0, {8'hA5, 24'd1});
    measure(n_oe, n_proc, n_peri);
    check_eq("R1 exponent 13", n_oe, 16384);
    settle_and_cause("R1 R8", 3);
    bus_write(1'b1, mode_word(8'hA5, 15));
    bus_write(1'b0, {8'hA5, 24'd1});
    measure(n_oe, n_proc, n_peri);
    check_eq("R1 exponent 15", n_oe, 65536);
    settle_and_cause("R1 R8", 3);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule